// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache

This block sits between a processor load/store port and a slower main memory. It holds recently used 32-byte lines in two ways per set, answers hits from its own arrays, and on a miss brings the whole line in from memory as a four-beat burst of 64-bit words. Writes carry a byte mask, so anything from a single byte up to a full 64-bit word can be stored. The mask is applied only after the tag compare has confirmed that the line is present.

The write policy is fixed by a parameter when the block is elaborated. In write-back mode, writes stay in the cache and mark the line dirty. A write miss first allocates the line and then merges the data, and a dirty line goes back to memory only when it is evicted. In write-through mode, every write goes to memory as a single masked word and also updates the cache on a hit. A write miss in this mode does not allocate a line. The number of sets is a parameter, so a test can use a small instance. The controller serves one request at a time and keeps the processor waiting until that request is finished.

Top module: `cache2w_top`

## Requirements
- R1: The address is split into a tag (upper bits), a set index in bits [5+log2(SETS)-1:5] (bits [8:5] for 16 sets, which is the line number modulo SETS), and a word select in bits [4:3]. Lines in different sets never disturb each other, and a line may be held in either way of its set.
- R2: After reset, every line is invalid, `cpu_ready` is 1 and `cpu_done` is 0, so the first access to any address misses.
- R3: A request is taken in a cycle where `cpu_req` and `cpu_ready` are both 1. `cpu_ready` then stays 0 until the request completes. Completion is a one-cycle `cpu_done` pulse, with read data on `cpu_rdata`. A hit completes two cycles after acceptance.
- R4: A read miss fetches the whole line as a four-beat read burst (`mem_burst`=1) at the line address, with bits [4:0] equal to 0. Later reads of any word in that line hit without memory traffic.
- R5: Bit b of `cpu_be` enables byte lane b (bits 8b+7:8b) of the 64-bit word. Only the enabled bytes change.
- R6: In write-back mode, a write hit updates only the cache and marks the line dirty. No memory transfer takes place.
- R7: In write-back mode, evicting a dirty line first writes all four of its words to memory as a write burst at the line address of the victim, and then refills. Evicting a clean line causes no memory write.
- R8: In write-back mode, a write miss refills the line from memory and then applies the masked write in the cache. Memory keeps its old value.
- R9: In write-through mode, every write produces exactly one single-beat memory write (`mem_burst`=0) at the word-aligned address with the CPU byte mask, and a hit also updates the cached copy. There is never a write burst.
- R10: In write-through mode, a write miss does not allocate a line, so a later read of that address misses and refills.
- R11: The victim is way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the way not used most recently. Every hit and every fill counts as a use.
- R12: `mem_req`, `mem_we` and `mem_addr` stay stable from the start of a transfer until its final `mem_ack`. Burst beats move words 0 to 3 of the line in order, one word per acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_be | input | 8 | Byte lane enables for writes |
| cpu_wdata | input | 64 | Write data |
| cpu_ready | output | 1 | Controller idle, can accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 64 | Read data, valid with `cpu_done` |
| mem_req | output | 1 | Memory transfer active |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_burst | output | 1 | 1 = four-beat line burst, 0 = single word |
| mem_addr | output | 32 | Line address (burst) or word address (single) |
| mem_wdata | output | 64 | Write data for the current beat |
| mem_be | output | 8 | Byte enables for the current beat |
| mem_ack | input | 1 | Memory accepts or returns one beat |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |

## Verification
The situation hardest to reach from the ports is the eviction of a dirty line that is not the most recently used one. To get there, both ways of one set must first be filled. A write then has to dirty one of them. Hits must then steer the recency bit while clean lines of other tags cycle through the other way, so that a clean victim can be seen causing no write burst. Only after that does the dirty line become the victim. The directed sequence does all of this in set 2 with tags spaced 0x200 apart. It checks the burst counters and memory contents of a behavioural memory after every step, and it touches a neighbouring set in between to show that sets are isolated.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 64;
    localparam int BE_W       = WORD_W / 8;
    localparam int LINE_BYTES = 32;
    localparam int OFS_W      = $clog2(LINE_BYTES);
    localparam int WORDS      = LINE_BYTES / BE_W;
    localparam int WSEL_W     = $clog2(WORDS);
    localparam int WAYS       = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMP,
        ST_WB,
        ST_FILL,
        ST_WT,
        ST_RSP
    } ctl_state_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
        logic [WORD_W-1:0] wdata;
    } cpu_req_t;

    function automatic logic [WSEL_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        return a[OFS_W-1 -: WSEL_W];
    endfunction
endpackage

// File: rtl/cache2w_tags.sv
module cache2w_tags
    import cache2w_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int IDX_W = $clog2(SETS),
    parameter int TAG_W = ADDR_W - IDX_W - OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] set_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic [WAYS-1:0]  hit_o,
    output logic             vic_way_o,
    output logic             vic_dirty_o,
    output logic [TAG_W-1:0] vic_tag_o,
    input  logic             touch_en,
    input  logic             touch_way,
    input  logic             fill_en,
    input  logic             fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             dirty_en,
    input  logic             dirty_way
);
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic [SETS-1:0]  lru_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_o[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
    end

    always_comb begin
        if (!valid_q[set_i][0])      vic_way_o = 1'b0;
        else if (!valid_q[set_i][1]) vic_way_o = 1'b1;
        else                         vic_way_o = lru_q[set_i];
        vic_dirty_o = dirty_q[set_i][vic_way_o] && valid_q[set_i][vic_way_o];
        vic_tag_o   = tag_q[set_i][vic_way_o];
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[set_i][fill_way] <= fill_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
            lru_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[set_i][fill_way] <= 1'b1;
                dirty_q[set_i][fill_way] <= 1'b0;
                lru_q[set_i]             <= ~fill_way;
            end
            if (touch_en) lru_q[set_i] <= ~touch_way;
            if (dirty_en) dirty_q[set_i][dirty_way] <= 1'b1;
        end
    end

    // a block may live in only one way of its set
    assert_single_way_hit_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(hit_o) <= 1);

    // a refill is only installed when the lookup missed
    assert_fill_on_miss_R11: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> (hit_o == '0));
endmodule

// File: rtl/cache2w_data.sv
module cache2w_data
    import cache2w_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  set_i,
    input  logic              rd_way,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [WORD_W-1:0] rdata_o,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [WORD_W-1:0] wr_data
);
    logic [WORD_W-1:0] line_q [SETS][WAYS][WORDS];

    assign rdata_o = line_q[set_i][rd_way][rd_word];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wr_be[b]) line_q[set_i][wr_way][wr_word][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end

    // every array write carries at least one enabled byte lane
    assert_write_has_lanes_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_be != '0));
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
    import cache2w_pkg::*;
#(
    parameter int SETS       = 16,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_burst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [BE_W-1:0]   mem_be,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(BE_W - 1);

    ctl_state_e        state_q;
    cpu_req_t          req_q;
    logic [WSEL_W-1:0] beat_q;
    logic              vic_way_q;
    logic [TAG_W-1:0]  vic_tag_q;
    logic [WORD_W-1:0] rdata_q;

    logic [IDX_W-1:0]  set_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WSEL_W-1:0] req_word;
    logic [WAYS-1:0]   hit_vec;
    logic              hit, hit_way;
    logic              vic_way, vic_dirty;
    logic [TAG_W-1:0]  vic_tag;

    logic              touch_en, fill_en, dirty_en;
    logic              d_rd_way, d_wr_en, d_wr_way;
    logic [WSEL_W-1:0] d_rd_word, d_wr_word;
    logic [BE_W-1:0]   d_wr_be;
    logic [WORD_W-1:0] d_wr_data, d_rdata;

    assign set_idx  = req_q.addr[OFS_W +: IDX_W];
    assign req_tag  = req_q.addr[ADDR_W-1 -: TAG_W];
    assign req_word = word_of(req_q.addr);
    assign hit      = |hit_vec;
    assign hit_way  = hit_vec[1];

    cache2w_tags #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst        (rst),
        .set_i      (set_idx),
        .tag_i      (req_tag),
        .hit_o      (hit_vec),
        .vic_way_o  (vic_way),
        .vic_dirty_o(vic_dirty),
        .vic_tag_o  (vic_tag),
        .touch_en   (touch_en),
        .touch_way  (hit_way),
        .fill_en    (fill_en),
        .fill_way   (vic_way_q),
        .fill_tag   (req_tag),
        .dirty_en   (dirty_en),
        .dirty_way  (hit_way)
    );

    cache2w_data #(.SETS(SETS), .IDX_W(IDX_W)) u_data (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_idx),
        .rd_way (d_rd_way),
        .rd_word(d_rd_word),
        .rdata_o(d_rdata),
        .wr_en  (d_wr_en),
        .wr_way (d_wr_way),
        .wr_word(d_wr_word),
        .wr_be  (d_wr_be),
        .wr_data(d_wr_data)
    );

    always_comb begin
        touch_en  = 1'b0;
        fill_en   = 1'b0;
        dirty_en  = 1'b0;
        d_rd_way  = hit_way;
        d_rd_word = req_word;
        d_wr_en   = 1'b0;
        d_wr_way  = hit_way;
        d_wr_word = req_word;
        d_wr_be   = req_q.be;
        d_wr_data = req_q.wdata;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_burst = 1'b0;
        mem_addr  = {req_tag, set_idx, {OFS_W{1'b0}}};
        mem_wdata = d_rdata;
        mem_be    = '1;
        case (state_q)
            ST_CMP: begin
                if (hit) begin
                    touch_en = 1'b1;
                    if (req_q.we) begin
                        d_wr_en  = 1'b1;
                        dirty_en = WRITE_BACK;
                    end
                end
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_burst = 1'b1;
                mem_addr  = {vic_tag_q, set_idx, {OFS_W{1'b0}}};
                d_rd_way  = vic_way_q;
                d_rd_word = beat_q;
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                mem_burst = 1'b1;
                if (mem_ack) begin
                    d_wr_en   = 1'b1;
                    d_wr_way  = vic_way_q;
                    d_wr_word = beat_q;
                    d_wr_be   = '1;
                    d_wr_data = mem_rdata;
                    fill_en   = (beat_q == LAST_BEAT);
                end
            end
            ST_WT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = req_q.addr & WORD_MASK;
                mem_wdata = req_q.wdata;
                mem_be    = req_q.be;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            req_q     <= '0;
            beat_q    <= '0;
            vic_way_q <= 1'b0;
            vic_tag_q <= '0;
            rdata_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        req_q.we    <= cpu_we;
                        req_q.addr  <= cpu_addr;
                        req_q.be    <= cpu_be;
                        req_q.wdata <= cpu_wdata;
                        state_q     <= ST_CMP;
                    end
                end
                ST_CMP: begin
                    if (hit) begin
                        if (!req_q.we) rdata_q <= d_rdata;
                        state_q <= (req_q.we && !WRITE_BACK) ? ST_WT : ST_RSP;
                    end else if (req_q.we && !WRITE_BACK) begin
                        state_q <= ST_WT;
                    end else begin
                        vic_way_q <= vic_way;
                        vic_tag_q <= vic_tag;
                        beat_q    <= '0;
                        state_q   <= (WRITE_BACK && vic_dirty) ? ST_WB : ST_FILL;
                    end
                end
                ST_WB: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST_BEAT) state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST_BEAT) state_q <= ST_CMP;
                    end
                end
                ST_WT: begin
                    if (mem_ack) state_q <= ST_RSP;
                end
                ST_RSP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cpu_ready = (state_q == ST_IDLE);
    assign cpu_done  = (state_q == ST_RSP);
    assign cpu_rdata = rdata_q;

    assert_ready_drops_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_ready) |=> !cpu_ready);

    assert_done_returns_idle_R3: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> (cpu_ready && !cpu_done));

    assert_burst_aligned_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_burst) |-> (mem_addr[OFS_W-1:0] == '0));

    assert_mem_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    if (!WRITE_BACK) begin : g_wt_chk
        assert_no_write_burst_R9: assert property (@(posedge clk) disable iff (rst)
            (mem_req && mem_we) |-> !mem_burst);
    end
endmodule

// File: tb/tb_cache2w_top.sv
`timescale 1ns/1ps

module tb_mem_model #(
    parameter int DEPTH = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic        we,
    input  logic        burst,
    input  logic [31:0] addr,
    input  logic [63:0] wdata,
    input  logic [7:0]  be,
    output logic        ack,
    output logic [63:0] rdata
);
    logic [63:0] mem [DEPTH];
    int          rd_bursts = 0;
    int          wr_bursts = 0;
    int          single_wr = 0;
    logic [31:0] last_wr_addr = '0;
    logic [31:0] last_rd_addr = '0;
    int          beat = 0;
    int          idx;

    function automatic logic [63:0] seed(input int i);
        return {16'hC0DE, 16'(i), 16'(i * 7 + 3), 16'hF00D ^ 16'(i)};
    endfunction

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = seed(i);
        ack   = 1'b0;
        rdata = '0;
    end

    always @(posedge clk) begin
        if (rst) begin
            ack  <= 1'b0;
            beat = 0;
        end else if (req && !ack) begin
            idx = int'(addr[12:3]) + (burst ? beat : 0);
            if (we) begin
                for (int b = 0; b < 8; b++)
                    if (be[b]) mem[idx][b*8 +: 8] = wdata[b*8 +: 8];
            end else begin
                rdata <= mem[idx];
            end
            ack <= 1'b1;
        end else if (ack) begin
            ack <= 1'b0;
            if (!burst || beat == 3) begin
                beat = 0;
                if (!burst) single_wr++;
                else if (we) begin wr_bursts++; last_wr_addr = addr; end
                else begin rd_bursts++; last_rd_addr = addr; end
            end else begin
                beat++;
            end
        end
    end
endmodule

module tb_cache2w_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        c_req[2], c_we[2], c_ready[2], c_done[2];
    logic [31:0] c_addr[2];
    logic [7:0]  c_be[2];
    logic [63:0] c_wd[2], c_rd[2];
    logic        m_req[2], m_we[2], m_burst[2], m_ack[2];
    logic [31:0] m_addr[2];
    logic [63:0] m_wd[2], m_rd[2];
    logic [7:0]  m_be[2];

    int checks = 0;
    int fails  = 0;
    bit done_all = 1'b0;

    initial begin
        for (int i = 0; i < 2; i++) begin
            c_req[i] = 1'b0; c_we[i] = 1'b0; c_addr[i] = '0; c_be[i] = '0; c_wd[i] = '0;
        end
    end

    cache2w_top #(.SETS(16), .WRITE_BACK(1'b1)) dut (
        .clk(clk), .rst(rst),
        .cpu_req(c_req[0]), .cpu_we(c_we[0]), .cpu_addr(c_addr[0]), .cpu_be(c_be[0]),
        .cpu_wdata(c_wd[0]), .cpu_ready(c_ready[0]), .cpu_done(c_done[0]), .cpu_rdata(c_rd[0]),
        .mem_req(m_req[0]), .mem_we(m_we[0]), .mem_burst(m_burst[0]), .mem_addr(m_addr[0]),
        .mem_wdata(m_wd[0]), .mem_be(m_be[0]), .mem_ack(m_ack[0]), .mem_rdata(m_rd[0])
    );

    cache2w_top #(.SETS(16), .WRITE_BACK(1'b0)) dut_wt (
        .clk(clk), .rst(rst),
        .cpu_req(c_req[1]), .cpu_we(c_we[1]), .cpu_addr(c_addr[1]), .cpu_be(c_be[1]),
        .cpu_wdata(c_wd[1]), .cpu_ready(c_ready[1]), .cpu_done(c_done[1]), .cpu_rdata(c_rd[1]),
        .mem_req(m_req[1]), .mem_we(m_we[1]), .mem_burst(m_burst[1]), .mem_addr(m_addr[1]),
        .mem_wdata(m_wd[1]), .mem_be(m_be[1]), .mem_ack(m_ack[1]), .mem_rdata(m_rd[1])
    );

    tb_mem_model mdl0 (.clk(clk), .rst(rst), .req(m_req[0]), .we(m_we[0]), .burst(m_burst[0]),
        .addr(m_addr[0]), .wdata(m_wd[0]), .be(m_be[0]), .ack(m_ack[0]), .rdata(m_rd[0]));
    tb_mem_model mdl1 (.clk(clk), .rst(rst), .req(m_req[1]), .we(m_we[1]), .burst(m_burst[1]),
        .addr(m_addr[1]), .wdata(m_wd[1]), .be(m_be[1]), .ack(m_ack[1]), .rdata(m_rd[1]));

    function automatic logic [63:0] seed(input int i);
        return {16'hC0DE, 16'(i), 16'(i * 7 + 3), 16'hF00D ^ 16'(i)};
    endfunction

    function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] nw,
                                          input logic [7:0] be);
        logic [63:0] r = old;
        for (int b = 0; b < 8; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic access(input int s, input bit we, input logic [31:0] a, input logic [7:0] be,
                          input logic [63:0] wd, output logic [63:0] rd, output int cyc,
                          output bit leak);
        @(negedge clk);
        while (!c_ready[s]) @(negedge clk);
        c_req[s] = 1'b1; c_we[s] = we; c_addr[s] = a; c_be[s] = be; c_wd[s] = wd;
        @(negedge clk);
        c_req[s] = 1'b0;
        cyc  = 1;
        leak = 1'b0;
        while (!c_done[s]) begin
            if (c_ready[s]) leak = 1'b1;
            @(negedge clk);
            cyc++;
        end
        rd = c_rd[s];
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(c_ready[0] && c_ready[1], "R2", "ready after reset", 64'(c_ready[0]), 64'd1);
        check(!c_done[0] && !c_done[1], "R2", "done low after reset", 64'(c_done[0]), 64'd0);
    endtask

    task automatic t_wb_fill_and_hit();
        logic [63:0] rd, x;
        int cyc, rb;
        bit leak;
        x = 64'h1122_3344_5566_7788;
        access(0, 0, 32'h58, 8'hFF, '0, rd, cyc, leak);
        check(rd == seed(11), "R4", "read miss data", rd, seed(11));
        check(mdl0.rd_bursts == 1, "R2", "first access misses", 64'(mdl0.rd_bursts), 64'd1);
        check(mdl0.last_rd_addr == 32'h40, "R4", "refill line address", 64'(mdl0.last_rd_addr), 64'h40);
        check(!leak, "R3", "ready low through miss", 64'(leak), 64'd0);
        rb = mdl0.rd_bursts;
        access(0, 0, 32'h48, 8'hFF, '0, rd, cyc, leak);
        check(rd == seed(9), "R1", "word select on hit", rd, seed(9));
        check(cyc == 2, "R3", "read hit latency", 64'(cyc), 64'd2);
        check(mdl0.rd_bursts == rb, "R4", "hit in filled line", 64'(mdl0.rd_bursts), 64'(rb));
        access(0, 0, 32'h40, 8'hFF, '0, rd, cyc, leak);
        check(rd == seed(8), "R12", "beat 0 placed in word 0", rd, seed(8));
        access(0, 0, 32'h50, 8'hFF, '0, rd, cyc, leak);
        check(rd == seed(10), "R12", "beat 2 placed in word 2", rd, seed(10));
        access(0, 1, 32'h48, 8'h0F, x, rd, cyc, leak);
        check(cyc == 2, "R6", "write hit latency", 64'(cyc), 64'd2);
        access(0, 0, 32'h48, 8'hFF, '0, rd, cyc, leak);
        check(rd == merge(seed(9), x, 8'h0F), "R5", "masked merge", rd, merge(seed(9), x, 8'h0F));
        check(mdl0.mem[9] == seed(9), "R6", "memory untouched on write hit", mdl0.mem[9], seed(9));
        check(mdl0.wr_bursts == 0 && mdl0.single_wr == 0, "R6", "no memory write",
              64'(mdl0.wr_bursts + mdl0.single_wr), 64'd0);
    endtask

    task automatic t_wb_replace();
        logic [63:0] rd, mrg;
        int cyc, rb, wb;
        bit leak;
        mrg = merge(seed(9), 64'h1122_3344_5566_7788, 8'h0F);
        access(0, 0, 32'h240, 8'hFF, '0, rd, cyc, leak);
        check(mdl0.wr_bursts == 0, "R11", "invalid way filled first", 64'(mdl0.wr_bursts), 64'd0);
        access(0, 0, 32'h060, 8'hFF, '0, rd, cyc, leak);
        access(0, 0, 32'h040, 8'hFF, '0, rd, cyc, leak);
        check(cyc == 2, "R1", "other set leaves set 2 intact", 64'(cyc), 64'd2);
        rb = mdl0.rd_bursts;
        access(0, 0, 32'h440, 8'hFF, '0, rd, cyc, leak);
        check(mdl0.wr_bursts == 0, "R7", "clean victim dropped", 64'(mdl0.wr_bursts), 64'd0);
        check(mdl0.rd_bursts == rb + 1, "R7", "refill on replace", 64'(mdl0.rd_bursts), 64'(rb + 1));
        access(0, 0, 32'h048, 8'hFF, '0, rd, cyc, leak);
        check(cyc == 2 && rd == mrg, "R11", "recently used line kept", rd, mrg);
        access(0, 0, 32'h640, 8'hFF, '0, rd, cyc, leak);
        check(mdl0.wr_bursts == 0, "R11", "LRU way evicted", 64'(mdl0.wr_bursts), 64'd0);
        wb = mdl0.wr_bursts;
        access(0, 0, 32'h840, 8'hFF, '0, rd, cyc, leak);
        check(mdl0.wr_bursts == wb + 1, "R7", "dirty victim written", 64'(mdl0.wr_bursts), 64'(wb + 1));
        check(mdl0.last_wr_addr == 32'h40, "R7", "victim line address", 64'(mdl0.last_wr_addr), 64'h40);
        check(mdl0.mem[9] == mrg, "R7", "dirty word reached memory", mdl0.mem[9], mrg);
        check(mdl0.mem[8] == seed(8), "R7", "clean word rewritten intact", mdl0.mem[8], seed(8));
        rb = mdl0.rd_bursts;
        access(0, 0, 32'h048, 8'hFF, '0, rd, cyc, leak);
        check(rd == mrg && mdl0.rd_bursts == rb + 1, "R7", "evicted line refetched", rd, mrg);
    endtask

    task automatic t_wb_write_miss();
        logic [63:0] rd, y, exp;
        int cyc, rb;
        bit leak;
        y   = 64'hA1B2_C3D4_E5F6_0718;
        exp = merge(seed(34), y, 8'hF0);
        rb  = mdl0.rd_bursts;
        access(0, 1, 32'h110, 8'hF0, y, rd, cyc, leak);
        check(mdl0.rd_bursts == rb + 1, "R8", "write miss allocates", 64'(mdl0.rd_bursts), 64'(rb + 1));
        check(mdl0.mem[34] == seed(34), "R8", "memory keeps old word", mdl0.mem[34], seed(34));
        access(0, 0, 32'h110, 8'hFF, '0, rd, cyc, leak);
        check(cyc == 2 && rd == exp, "R8", "merged after refill", rd, exp);
    endtask

    task automatic t_wt_paths();
        logic [63:0] rd, z, w, e16, e17;
        int cyc;
        bit leak;
        z   = 64'h0F0E_0D0C_0B0A_0908;
        w   = 64'h7766_5544_3322_1100;
        e16 = merge(seed(16), z, 8'h03);
        e17 = merge(seed(17), w, 8'hF0);
        access(1, 1, 32'h080, 8'h03, z, rd, cyc, leak);
        check(mdl1.single_wr == 1, "R9", "write miss goes to memory", 64'(mdl1.single_wr), 64'd1);
        check(mdl1.mem[16] == e16, "R9", "masked memory write", mdl1.mem[16], e16);
        check(mdl1.rd_bursts == 0, "R10", "no allocate on write miss", 64'(mdl1.rd_bursts), 64'd0);
        access(1, 0, 32'h080, 8'hFF, '0, rd, cyc, leak);
        check(mdl1.rd_bursts == 1 && rd == e16, "R10", "later read misses", rd, e16);
        access(1, 1, 32'h088, 8'hF0, w, rd, cyc, leak);
        check(mdl1.single_wr == 2 && mdl1.mem[17] == e17, "R9", "write hit reaches memory",
              mdl1.mem[17], e17);
        access(1, 0, 32'h088, 8'hFF, '0, rd, cyc, leak);
        check(cyc == 2 && rd == e17 && mdl1.rd_bursts == 1, "R9", "write hit updates cache", rd, e17);
        access(1, 0, 32'h280, 8'hFF, '0, rd, cyc, leak);
        access(1, 0, 32'h480, 8'hFF, '0, rd, cyc, leak);
        check(mdl1.wr_bursts == 0, "R9", "no write burst on eviction", 64'(mdl1.wr_bursts), 64'd0);
    endtask

    initial begin
        t_reset();
        t_wb_fill_and_hit();
        t_wb_replace();
        t_wb_write_miss();
        t_wt_paths();
        if (!done_all) begin
            done_all = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_all) begin
            done_all = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule